// File: doc/BRIEF.md
# Run-Time Configurable Sum-of-Products Logic Array

This block is a small programmable logic array: four logic inputs, eight product-term rows and three outputs. Every row forms the AND of any chosen subset of the eight literals (each input in true and inverted form). Every output forms the OR of any chosen subset of rows. Both connection matrices live in flip-flops and are loaded after reset over a one-bit serial port. Once the whole map is in, a done flag rises and the outputs follow the inputs combinationally.

A mode pin changes how the OR matrix is used. In programmable mode, each output uses its own row-select bits, and one row may serve several outputs. In fixed mode, each output owns a hard-wired group of rows and its row-select bits have no effect. Registered outputs, tri-state drivers and non-volatile storage are not part of this block.

Top module: `pla_array`

## Requirements
- R1: A row includes a literal when that literal's connection bit is 1 and excludes it when the bit is 0. Within a row's 8-bit field, bit 2i selects input i in true form and bit 2i+1 selects input i inverted. A row with connected literals evaluates to the AND of those literals.
- R2: A row with no connection bit set evaluates to 0 for every input value.
- R3: A row that connects both the true and the inverted form of one input evaluates to 0 for every input value.
- R4: When `fixedOr` is 0, output o is the OR of every row r whose bit r is set in output o's 8-bit select field. One row may drive several outputs at once.
- R5: When `fixedOr` is 1, output 0 is the OR of rows 0–2, output 1 is the OR of rows 3–5 and output 2 is the OR of rows 6–7. All OR-matrix bits are ignored in this mode.
- R6: Each configuration bit is presented on `cfgBit` with `cfgValid` high, one per clock, most significant bit first. Rows 0 to 7 come first, each with bit 7 first. Then the select fields of outputs 0 to 2 follow, each with bit 7 (row 7) first.
- R7: `done` is low until exactly 88 configuration bits have been accepted. It becomes visible after the clock edge that accepts the 88th bit, and it then stays high until reset.
- R8: While `done` is low, all outputs are 0, including during a partial load.
- R9: After `done` is high, further `cfgValid` pulses do not change the loaded map, and the outputs stay as the loaded map defines them.
- R10: A synchronous reset clears both matrices, the bit count and `done`.
- R11: Loaded with rows M·L', T', O and M·T' and a shared O row (M, L, T, O on inputs 0 to 3), in programmable mode the outputs are out0 = M·L' + O, out1 = T' + O and out2 = M·T' + O.
- R12: Loaded with the four odd-parity minterms of inputs 0 to 2 and ORed into output 0, output 0 equals the XOR of inputs 0, 1 and 2 in programmable mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgValid | input | 1 | Qualifies a configuration bit |
| cfgBit | input | 1 | Serial configuration data |
| fixedOr | input | 1 | 1 selects fixed row groups for the OR stage |
| dataIn | input | 4 | Logic inputs |
| done | output | 1 | Configuration complete |
| dataOut | output | 3 | Logic outputs |

## Verification
The bench loads three maps. The first has a row shared by all three outputs; a design that did not let rows be shared would drop O from two of the outputs. The second contains an empty row and a contradictory row; a design that treated an empty row as a true AND would light output 2, and one that ignored the conflict would leave output 1 depending on the input. The third loads single-literal rows with an all-zero OR matrix; a design with a reversed bit order would select the wrong literals, and one that still read the OR bits in fixed mode would hold the outputs at zero. Checks on `done` across the 87th and 88th bits, on shifting after completion, and on a partial load after reset catch an off-by-one count, an unfrozen map and outputs that are not gated off.

// File: rtl/pla_pkg.sv
package pla_pkg;
  parameter int NUM_IN   = 4;
  parameter int NUM_ROWS = 8;
  parameter int NUM_OUT  = 3;

  typedef struct packed {
    logic shiftEn;
    logic clearAll;
  } cfgStrobe_t;
endpackage

// File: rtl/pla_cfg_ctrl.sv
module pla_cfg_ctrl
  import pla_pkg::*;
#(
  parameter int TOTAL_BITS = 88
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgValid,
  output cfgStrobe_t strobe,
  output logic       done
);
  localparam int CNT_W = $clog2(TOTAL_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TOTAL_BITS);

  logic [CNT_W-1:0] bitCnt;

  // Accept bits only while the map is still incomplete.
  assign strobe.shiftEn  = cfgValid & ~done;
  assign strobe.clearAll = rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
      done   <= 1'b0;
    end else if (strobe.shiftEn) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == LAST_IDX) done <= 1'b1;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R7
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(cfgValid) && $past(bitCnt) == LAST_IDX)); // R7
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= CNT_MAX); // R7
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(bitCnt)); // R9
endmodule

// File: rtl/pla_fuse_store.sv
module pla_fuse_store
  import pla_pkg::*;
#(
  parameter int NUM_IN   = pla_pkg::NUM_IN,
  parameter int NUM_ROWS = pla_pkg::NUM_ROWS,
  parameter int NUM_OUT  = pla_pkg::NUM_OUT
) (
  input  logic                                   clk,
  input  cfgStrobe_t                             strobe,
  input  logic                                   cfgBit,
  output logic [NUM_ROWS-1:0][2*NUM_IN-1:0]      andPlane,
  output logic [NUM_OUT-1:0][NUM_ROWS-1:0]       orPlane
);
  localparam int LIT_W      = 2 * NUM_IN;
  localparam int AND_BITS   = NUM_ROWS * LIT_W;
  localparam int OR_BITS    = NUM_OUT * NUM_ROWS;
  localparam int TOTAL_BITS = AND_BITS + OR_BITS;

  // The earliest bit ends up in the top position after a full load.
  logic [TOTAL_BITS-1:0] fuseReg;

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      fuseReg <= '0;
    end else if (strobe.shiftEn) begin
      fuseReg <= {fuseReg[TOTAL_BITS-2:0], cfgBit};
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_andRow
    assign andPlane[r] = fuseReg[TOTAL_BITS-1-r*LIT_W -: LIT_W];
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_orCol
    assign orPlane[o] = fuseReg[OR_BITS-1-o*NUM_ROWS -: NUM_ROWS];
  end

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (strobe.clearAll)
    strobe.shiftEn |=> (fuseReg[0] == $past(cfgBit))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (strobe.clearAll)
    !strobe.shiftEn |=> $stable(fuseReg)); // R9
endmodule

// File: rtl/pla_plane_eval.sv
module pla_plane_eval #(
  parameter int NUM_IN   = pla_pkg::NUM_IN,
  parameter int NUM_ROWS = pla_pkg::NUM_ROWS,
  parameter int NUM_OUT  = pla_pkg::NUM_OUT
) (
  input  logic [NUM_IN-1:0]                    dataIn,
  input  logic [NUM_ROWS-1:0][2*NUM_IN-1:0]    andPlane,
  input  logic [NUM_OUT-1:0][NUM_ROWS-1:0]     orPlane,
  input  logic                                 fixedOr,
  input  logic                                 enable,
  output logic [NUM_OUT-1:0]                   dataOut
);
  localparam int LIT_W = 2 * NUM_IN;

  // Rows owned by output o in fixed mode: row r maps to floor(r*NUM_OUT/NUM_ROWS).
  function automatic logic [NUM_ROWS-1:0] groupMask(input int o);
    logic [NUM_ROWS-1:0] m;
    m = '0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      m[r] = ((r * NUM_OUT) / NUM_ROWS) == o;
    end
    return m;
  endfunction

  logic [LIT_W-1:0]    literals;
  logic [NUM_ROWS-1:0] rowVal;
  logic [NUM_OUT-1:0]  sumOut;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign literals[2*i]   = dataIn[i];
    assign literals[2*i+1] = ~dataIn[i];
  end

  // An empty row is forced low; otherwise every connected literal must be 1.
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign rowVal[r] = (|andPlane[r]) & (&(~andPlane[r] | literals));
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_sum
    localparam logic [NUM_ROWS-1:0] GROUP = groupMask(o);
    logic [NUM_ROWS-1:0] selRows;
    assign selRows   = fixedOr ? GROUP : orPlane[o];
    assign sumOut[o] = |(rowVal & selRows);
  end

  assign dataOut = enable ? sumOut : '0;
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int NUM_IN   = pla_pkg::NUM_IN,
  parameter int NUM_ROWS = pla_pkg::NUM_ROWS,
  parameter int NUM_OUT  = pla_pkg::NUM_OUT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgValid,
  input  logic               cfgBit,
  input  logic               fixedOr,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic               done,
  output logic [NUM_OUT-1:0] dataOut
);
  localparam int TOTAL_BITS = NUM_ROWS * 2 * NUM_IN + NUM_OUT * NUM_ROWS;

  cfgStrobe_t                          strobe;
  logic [NUM_ROWS-1:0][2*NUM_IN-1:0]   andPlane;
  logic [NUM_OUT-1:0][NUM_ROWS-1:0]    orPlane;

  pla_cfg_ctrl #(.TOTAL_BITS(TOTAL_BITS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfgValid (cfgValid),
    .strobe   (strobe),
    .done     (done)
  );

  pla_fuse_store #(.NUM_IN(NUM_IN), .NUM_ROWS(NUM_ROWS), .NUM_OUT(NUM_OUT)) u_store (
    .clk      (clk),
    .strobe   (strobe),
    .cfgBit   (cfgBit),
    .andPlane (andPlane),
    .orPlane  (orPlane)
  );

  pla_plane_eval #(.NUM_IN(NUM_IN), .NUM_ROWS(NUM_ROWS), .NUM_OUT(NUM_OUT)) u_eval (
    .dataIn   (dataIn),
    .andPlane (andPlane),
    .orPlane  (orPlane),
    .fixedOr  (fixedOr),
    .enable   (done),
    .dataOut  (dataOut)
  );

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !done |-> (dataOut == '0)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!done && andPlane == '0 && orPlane == '0)); // R10
  AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(andPlane) && $stable(orPlane))); // R9
endmodule

// File: tb/pla_array_bench.sv
module pla_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NR = 8;
  localparam int NO = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgValid = 1'b0;
  logic cfgBit = 1'b0;
  logic fixedOr = 1'b0;
  logic [NI-1:0] dataIn = '0;
  logic done;
  logic [NO-1:0] dataOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [2*NI-1:0] mAnd [NR];
  logic [NR-1:0]   mOr  [NO];

  logic [NO-1:0] expQ [$];
  string         tagQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_array u_pla_array (
    .clk(clk), .rst(rst), .cfgValid(cfgValid), .cfgBit(cfgBit),
    .fixedOr(fixedOr), .dataIn(dataIn), .done(done), .dataOut(dataOut)
  );

  task automatic check(input string tag, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic logic [NO-1:0] model(input logic [NI-1:0] v, input logic fx);
    logic [NR-1:0] rows;
    logic [NO-1:0] res;
    for (int r = 0; r < NR; r++) begin
      rows[r] = (mAnd[r] != '0);
      for (int j = 0; j < 2*NI; j++) begin
        if (mAnd[r][j] && ((j % 2 == 0) ? !v[j/2] : v[j/2])) rows[r] = 1'b0;
      end
    end
    res = '0;
    for (int r = 0; r < NR; r++) begin
      int grp;
      grp = (r <= 2) ? 0 : ((r <= 5) ? 1 : 2);
      for (int o = 0; o < NO; o++) begin
        if (rows[r] && (fx ? (grp == o) : mOr[o][r])) res[o] = 1'b1;
      end
    end
    return res;
  endfunction

  // Driver: applies a stimulus and pushes the expected result.
  task automatic drive(input logic [NI-1:0] v, input logic fx, input logic [NO-1:0] exp, input string tag);
    @(negedge clk);
    dataIn  = v;
    fixedOr = fx;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  // Monitor: pops and compares a quarter period after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        logic [NO-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, dataOut, e);
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    cfgValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic loadMap();
    int n;
    n = 0;
    for (int r = 0; r < NR; r++) begin
      for (int b = 2*NI-1; b >= 0; b--) begin
        @(negedge clk);
        if (n == 87) check("R7 done before last bit", {2'b0, done}, 3'b000);
        cfgValid = 1'b1;
        cfgBit   = mAnd[r][b];
        n++;
      end
    end
    for (int o = 0; o < NO; o++) begin
      for (int b = NR-1; b >= 0; b--) begin
        @(negedge clk);
        if (n == 87) check("R7 done before last bit", {2'b0, done}, 3'b000);
        cfgValid = 1'b1;
        cfgBit   = mOr[o][b];
        n++;
      end
    end
    @(negedge clk);
    cfgValid = 1'b0;
    check("R7 done after 88 bits", {2'b0, done}, 3'b001);
  endtask

  task automatic sweepModel(input logic fx, input string tag);
    for (int v = 0; v < 16; v++) drive(4'(v), fx, model(4'(v), fx), tag);
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    doReset();
    @(negedge clk);
    check("R10 done after reset", {2'b0, done}, 3'b000);
    for (int v = 0; v < 16; v++) drive(4'(v), v[0], 3'b000, "R8 unconfigured outputs");
    drain();

    // Map A: M=in0, L=in1, T=in2, O=in3; row 2 (O) is shared.
    for (int r = 0; r < NR; r++) mAnd[r] = '0;
    mAnd[0] = 8'b0000_1001; // M & ~L
    mAnd[1] = 8'b0010_0000; // ~T
    mAnd[2] = 8'b0100_0000; // O
    mAnd[3] = 8'b0010_0001; // M & ~T
    mOr[0] = 8'b0000_0101;
    mOr[1] = 8'b0000_0110;
    mOr[2] = 8'b0000_1100;
    loadMap();
    for (int v = 0; v < 16; v++) begin
      logic m, l, t, o;
      m = v[0]; l = v[1]; t = v[2]; o = v[3];
      drive(4'(v), 1'b0, {(m & ~t) | o, ~t | o, (m & ~l) | o}, "R11 R1 smart-light terms");
    end
    sweepModel(1'b0, "R4 shared row");
    sweepModel(1'b1, "R5 fixed groups map A");
    drain();

    // Further shifting after completion must not disturb the map.
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      cfgValid = 1'b1;
      cfgBit   = 1'b1;
    end
    @(negedge clk);
    cfgValid = 1'b0;
    check("R9 done held", {2'b0, done}, 3'b001);
    sweepModel(1'b0, "R9 map frozen after done");
    drain();

    // Map B: odd parity on in0..in2, contradictory row 7, empty row 4.
    doReset();
    for (int r = 0; r < NR; r++) mAnd[r] = '0;
    mAnd[0] = 8'b0001_1010;
    mAnd[1] = 8'b0010_0110;
    mAnd[2] = 8'b0010_1001;
    mAnd[3] = 8'b0001_0101;
    mAnd[7] = 8'b0000_0011;
    mOr[0] = 8'b0000_1111;
    mOr[1] = 8'b1000_0000;
    mOr[2] = 8'b0001_0000;
    loadMap();
    for (int v = 0; v < 16; v++)
      drive(4'(v), 1'b0, {1'b0, 1'b0, ^v[2:0]}, "R12 R2 R3 parity, empty and contradictory rows");
    sweepModel(1'b1, "R5 fixed groups map B");
    drain();

    // Map C: single-literal rows, OR matrix all zero; checks bit order.
    doReset();
    for (int r = 0; r < NR; r++) mAnd[r] = '0;
    mAnd[0] = 8'b0000_0001; // in0
    mAnd[4] = 8'b0000_0100; // in1
    mAnd[7] = 8'b0001_0000; // in2
    for (int o = 0; o < NO; o++) mOr[o] = '0;
    loadMap();
    for (int v = 0; v < 16; v++)
      drive(4'(v), 1'b1, v[2:0], "R5 R6 fixed mode ignores OR bits");
    for (int v = 0; v < 16; v++)
      drive(4'(v), 1'b0, 3'b000, "R4 empty select fields");
    drain();

    // Reset after use, then a partial load.
    doReset();
    @(negedge clk);
    check("R10 done cleared", {2'b0, done}, 3'b000);
    for (int v = 0; v < 16; v++) drive(4'(v), 1'b1, 3'b000, "R10 outputs after reset");
    drain();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cfgValid = 1'b1;
      cfgBit   = 1'b1;
    end
    @(negedge clk);
    cfgValid = 1'b0;
    check("R8 done during partial load", {2'b0, done}, 3'b000);
    for (int v = 0; v < 16; v++) drive(4'(v), v[1], 3'b000, "R8 partial load outputs");
    drain();

    finishRun();
  end
endmodule